// File: doc/BRIEF.md
# Diskette Controller Host Register Front End

This block is the host-side register window of a four-drive diskette controller. The host reaches it with 8-bit port reads and writes in an aligned window of eight ports. The block decodes those accesses. It builds a subsystem status byte from the live drive-ready lines and its own interrupt flag. It collects a 16-bit parameter-block address one byte at a time and hands that address to a command engine with a one-clock start pulse. It keeps the completion result that the engine reports and shows it to the host as a result type and a result byte.

The engine and the drives are outside this block. The engine is seen only through a busy level, a done pulse with an interrupt-enable qualifier, an error flag and an error-bit byte. The drives are seen only through four ready lines. When the host writes the reset port, the block clears its own state and sends a one-clock reset pulse to the rest of the subsystem.

Top module: `fdc_host_regs`

## Requirements
- R1: After reset the interrupt flag is 0, the parameter address is 0x0000, the result type is 00, the result byte is 0x00, and neither eng_start nor sub_reset is asserted.
- R2: A read at offset 0 returns the status byte. Bit0 is drive0 ready, bit1 is drive1 ready, bit2 is the interrupt flag, bit3 is 1 (controller present), bit4 is 1 (double-density controller present, DD_PRESENT), bit5 is drive2 ready, bit6 is drive3 ready, and bit7 is 0.
- R3: A read at offset 1 returns the result type in bits 1:0, with bits 7:2 zero. Type 00 is an error completion and type 10 is a ready-status result. Types 01 and 11 are never produced.
- R4: A write at offset 1 loads eng_pb_addr[7:0] from the write data. It starts no operation.
- R5: A write at offset 2 loads eng_pb_addr[15:8]. eng_start is then high for exactly the one cycle after the write edge, and eng_pb_addr carries the full address during that cycle.
- R6: A write at offset 2 is ignored while eng_busy is high or while a start pulse is already out. It gives no start pulse and leaves the high address byte unchanged.
- R7: On eng_done with eng_err=1, the result type becomes 00 and the result byte (offset 3) becomes eng_err_bits. On eng_done with eng_err=0, the result type becomes 10 and the result byte reads bit4=drive2, bit5=drive3, bit6=drive0, bit7=drive1 ready, with bits 3:0 zero and the drive bits taken live.
- R8: The interrupt flag (the irq output and status bit2) sets on eng_done when eng_irq_en is 1. A done with eng_irq_en=0 leaves it unchanged.
- R9: A read of the result byte at offset 3 clears the interrupt flag. If eng_done with eng_irq_en arrives in the same cycle, the flag stays set.
- R10: A write at offset 7 pulses sub_reset for one cycle after the write edge. It also clears the interrupt flag, the parameter address and the result (type 00, byte 0x00).
- R11: Reads at offsets 2, 4, 5, 6 and 7, and at any port outside the window BASE_PORT..BASE_PORT+7, return 0x00. Writes at offsets 0, 3, 4, 5 and 6 change no state, and reads other than at offset 3 leave the interrupt flag alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | PORT_W | Host port address |
| io_rd | input | 1 | Host read strobe |
| io_wr | input | 1 | Host write strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, combinational while io_rd is high |
| drv_ready | input | 4 | Ready line of each drive, bit n for drive n |
| eng_busy | input | 1 | Command engine is executing |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_irq_en | input | 1 | Completion interrupt enabled for the finishing command |
| eng_err | input | 1 | Completion ended with an error |
| eng_err_bits | input | 8 | Error bits reported with an error completion |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_pb_addr | output | 16 | Parameter-block address |
| irq | output | 1 | Interrupt flag |
| sub_reset | output | 1 | One-cycle subsystem reset pulse |

## Verification
The hardest cases to reach are the collisions. These are a completion arriving in the same cycle as the host read that would clear the interrupt, and a second high-byte write arriving back to back with the first, before the engine has raised busy. The bench drives these cases directly. It holds io_rd at offset 3 while pulsing eng_done, and it keeps io_wr asserted across two edges with different data. It then checks that the flag stays set and that only one start pulse leaves with the first byte. Sweeps over all sixteen drive-ready patterns, all 256 error bytes and all 256 port addresses cover the byte layouts and the decode.

// File: rtl/fdc_regs_pkg.sv
package fdc_regs_pkg;

  localparam int NUM_OFS = 8;
  localparam int OFS_W   = 3;

  localparam logic [OFS_W-1:0] OFS_STATUS = 3'd0;
  localparam logic [OFS_W-1:0] OFS_TYPE   = 3'd1;  // read: type, write: address low
  localparam logic [OFS_W-1:0] OFS_PB_HI  = 3'd2;
  localparam logic [OFS_W-1:0] OFS_RESULT = 3'd3;
  localparam logic [OFS_W-1:0] OFS_RESET  = 3'd7;

  typedef enum logic [1:0] {
    RT_ERROR = 2'b00,
    RT_RSV1  = 2'b01,
    RT_READY = 2'b10,
    RT_RSV3  = 2'b11
  } res_type_e;

  // Status byte: drive ready bits are split around the flag/presence field.
  function automatic logic [7:0] status_byte(input logic [3:0] rdy,
                                             input logic       flag,
                                             input logic       dd);
    status_byte = {1'b0, rdy[3], rdy[2], dd, 1'b1, flag, rdy[1], rdy[0]};
  endfunction

  // Ready-status result byte: drives 2,3 in bits 4,5 and drives 0,1 in bits 6,7.
  function automatic logic [7:0] ready_result(input logic [3:0] rdy);
    ready_result = {rdy[1], rdy[0], rdy[3], rdy[2], 4'b0000};
  endfunction

endpackage

// File: rtl/fdc_addr_decode.sv
module fdc_addr_decode #(
  parameter int                PORT_W    = 8,
  parameter logic [PORT_W-1:0] BASE_PORT = 8'h78
) (
  input  logic [PORT_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [7:0]        rd_stb,
  output logic [7:0]        wr_stb
);
  import fdc_regs_pkg::*;

  logic in_window;
  assign in_window = (io_addr[PORT_W-1:OFS_W] == BASE_PORT[PORT_W-1:OFS_W]);

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_ofs
    logic hit;
    assign hit       = in_window && (io_addr[OFS_W-1:0] == OFS_W'(g));
    assign rd_stb[g] = hit && io_rd;
    assign wr_stb[g] = hit && io_wr;
  end
endmodule

// File: rtl/fdc_cmd_launch.sv
module fdc_cmd_launch (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sys_clear,
  input  logic        lo_wr,
  input  logic        hi_wr,
  input  logic [7:0]  wdata,
  input  logic        eng_busy,
  output logic        start_ok,
  output logic [15:0] pb_addr,
  output logic        start
);
  logic [7:0] pb_lo_q, pb_hi_q;
  logic       start_q;

  assign start_ok = hi_wr && !eng_busy && !start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pb_lo_q <= 8'h00;
      pb_hi_q <= 8'h00;
      start_q <= 1'b0;
    end else if (sys_clear) begin
      pb_lo_q <= 8'h00;
      pb_hi_q <= 8'h00;
      start_q <= 1'b0;
    end else begin
      if (lo_wr)    pb_lo_q <= wdata;
      if (start_ok) pb_hi_q <= wdata;
      start_q <= start_ok;
    end
  end

  assign pb_addr = {pb_hi_q, pb_lo_q};
  assign start   = start_q;
endmodule

// File: rtl/fdc_result_keeper.sv
module fdc_result_keeper
  import fdc_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_clear,
  input  logic       done,
  input  logic       irq_en,
  input  logic       err,
  input  logic [7:0] err_bits,
  input  logic       result_rd,
  output res_type_e  res_type,
  output logic [7:0] err_q,
  output logic       flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_type <= RT_ERROR;
      err_q    <= 8'h00;
      flag     <= 1'b0;
    end else if (sys_clear) begin
      res_type <= RT_ERROR;
      err_q    <= 8'h00;
      flag     <= 1'b0;
    end else begin
      if (done) begin
        res_type <= err ? RT_ERROR : RT_READY;
        err_q    <= err ? err_bits : 8'h00;
      end
      if (done && irq_en)  flag <= 1'b1;
      else if (result_rd)  flag <= 1'b0;
    end
  end
endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
  import fdc_regs_pkg::*;
#(
  parameter int                PORT_W     = 8,
  parameter logic [PORT_W-1:0] BASE_PORT  = 8'h78,
  parameter logic              DD_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [3:0]        drv_ready,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic              eng_irq_en,
  input  logic              eng_err,
  input  logic [7:0]        eng_err_bits,
  output logic              eng_start,
  output logic [15:0]       eng_pb_addr,
  output logic              irq,
  output logic              sub_reset
);
  logic [7:0] rd_stb, wr_stb;
  logic       ev_sys_clear, ev_start_ok, ev_result_rd, ev_ro_write;
  res_type_e  res_type;
  logic [7:0] err_q;
  logic       flag;
  logic       sub_reset_q;
  logic [7:0] rd_val [NUM_OFS];

  fdc_addr_decode #(.PORT_W(PORT_W), .BASE_PORT(BASE_PORT)) u_dec (
    .io_addr (io_addr),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb)
  );

  assign ev_sys_clear = wr_stb[OFS_RESET];
  assign ev_result_rd = rd_stb[OFS_RESULT];
  assign ev_ro_write  = wr_stb[0] | wr_stb[3] | wr_stb[4] | wr_stb[5] | wr_stb[6];

  fdc_cmd_launch u_launch (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_clear (ev_sys_clear),
    .lo_wr     (wr_stb[OFS_TYPE]),
    .hi_wr     (wr_stb[OFS_PB_HI]),
    .wdata     (io_wdata),
    .eng_busy  (eng_busy),
    .start_ok  (ev_start_ok),
    .pb_addr   (eng_pb_addr),
    .start     (eng_start)
  );

  fdc_result_keeper u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_clear (ev_sys_clear),
    .done      (eng_done),
    .irq_en    (eng_irq_en),
    .err       (eng_err),
    .err_bits  (eng_err_bits),
    .result_rd (ev_result_rd),
    .res_type  (res_type),
    .err_q     (err_q),
    .flag      (flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sub_reset_q <= 1'b0;
    else        sub_reset_q <= ev_sys_clear;
  end

  // Per-offset read values; offsets without a readable register stay zero.
  always_comb begin
    for (int i = 0; i < NUM_OFS; i++) rd_val[i] = 8'h00;
    rd_val[OFS_STATUS] = status_byte(drv_ready, flag, DD_PRESENT);
    rd_val[OFS_TYPE]   = {6'b0, res_type};
    rd_val[OFS_RESULT] = (res_type == RT_READY) ? ready_result(drv_ready) : err_q;
  end

  always_comb begin
    io_rdata = 8'h00;
    for (int i = 0; i < NUM_OFS; i++)
      if (rd_stb[i]) io_rdata = io_rdata | rd_val[i];
  end

  assign irq       = flag;
  assign sub_reset = sub_reset_q;
endmodule

// File: rtl/fdc_host_regs_chk.sv
module fdc_host_regs_chk #(
  parameter int                PORT_W    = 8,
  parameter logic [PORT_W-1:0] BASE_PORT = 8'h78
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PORT_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [7:0]        io_rdata,
  input logic              eng_busy,
  input logic              eng_done,
  input logic              eng_irq_en,
  input logic              eng_start,
  input logic [15:0]       eng_pb_addr,
  input logic              irq,
  input logic              sub_reset,
  input logic              ev_ro_write
);
  localparam logic [PORT_W-1:0] A_STAT = BASE_PORT;
  localparam logic [PORT_W-1:0] A_TYPE = BASE_PORT + PORT_W'(1);
  localparam logic [PORT_W-1:0] A_HI   = BASE_PORT + PORT_W'(2);
  localparam logic [PORT_W-1:0] A_RES  = BASE_PORT + PORT_W'(3);
  localparam logic [PORT_W-1:0] A_RST  = BASE_PORT + PORT_W'(7);

  assert_status_layout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == A_STAT) |-> (!io_rdata[7] && io_rdata[3] && io_rdata[2] == irq));

  assert_type_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == A_TYPE) |-> (io_rdata[7:2] == 6'd0 && io_rdata[0] == 1'b0));

  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_start_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_start) |-> $past(io_wr && io_addr == A_HI && !eng_busy));

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(eng_done && eng_irq_en));

  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == A_RES && !(eng_done && eng_irq_en)) |=> !irq);

  assert_reset_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == A_RST) |=> (sub_reset && !irq && eng_pb_addr == 16'h0000));

  assert_ro_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ro_write |=> ($stable(eng_pb_addr) && !eng_start && !sub_reset));
endmodule

bind fdc_host_regs fdc_host_regs_chk #(.PORT_W(PORT_W), .BASE_PORT(BASE_PORT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_addr     (io_addr),
  .io_rd       (io_rd),
  .io_wr       (io_wr),
  .io_rdata    (io_rdata),
  .eng_busy    (eng_busy),
  .eng_done    (eng_done),
  .eng_irq_en  (eng_irq_en),
  .eng_start   (eng_start),
  .eng_pb_addr (eng_pb_addr),
  .irq         (irq),
  .sub_reset   (sub_reset),
  .ev_ro_write (ev_ro_write)
);

// File: tb/fdc_host_regs_bench.sv
module fdc_host_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] BASE = 8'h78;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  io_addr = 8'h00;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic [3:0]  drv_ready = 4'b0000;
  logic        eng_busy = 1'b0, eng_done = 1'b0, eng_irq_en = 1'b0, eng_err = 1'b0;
  logic [7:0]  eng_err_bits = 8'h00;
  logic        eng_start;
  logic [15:0] eng_pb_addr;
  logic        irq, sub_reset;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // bench-side model of the visible state
  logic       m_irq = 1'b0;
  logic [1:0] m_type = 2'b00;
  logic [7:0] m_err = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_host_regs u_fdc_host_regs (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .drv_ready(drv_ready),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_irq_en(eng_irq_en),
    .eng_err(eng_err), .eng_err_bits(eng_err_bits), .eng_start(eng_start),
    .eng_pb_addr(eng_pb_addr), .irq(irq), .sub_reset(sub_reset)
  );

  function automatic logic [7:0] exp_status(logic [3:0] r, logic f);
    return 8'((r & 4'h3) + (f ? 4 : 0) + 8 + 16 + ((r >> 2) * 32));
  endfunction

  function automatic logic [7:0] exp_ready(logic [3:0] r);
    return 8'(r[2] * 16 + r[3] * 32 + r[0] * 64 + r[1] * 128);
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] a, logic [3:0] r, logic f,
                                          logic [1:0] t, logic [7:0] e);
    if (a / 8 != BASE / 8) return 8'h00;
    case (a % 8)
      0: return exp_status(r, f);
      1: return {6'd0, t};
      3: return (t == 2'b10) ? exp_ready(r) : e;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(posedge clk);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic done_pulse(logic ie, logic er, logic [7:0] eb);
    @(negedge clk);
    eng_done = 1'b1; eng_irq_en = ie; eng_err = er; eng_err_bits = eb;
    @(posedge clk);
    @(negedge clk);
    eng_done = 1'b0; eng_irq_en = 1'b0; eng_err = 1'b0;
    if (ie) m_irq = 1'b1;
    m_type = er ? 2'b00 : 2'b10;
    m_err  = er ? eb : 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [15:0] pb;
    drv_ready = 4'b0101;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 irq", 16'(irq), 16'd0);
    check("R1 pb_addr", eng_pb_addr, 16'h0000);
    check("R1 start", 16'(eng_start), 16'd0);
    check("R1 sub_reset", 16'(sub_reset), 16'd0);
    io_read(BASE + 1, d); check("R1 type", 16'(d), 16'h00);
    io_read(BASE + 3, d); check("R1 result", 16'(d), 16'h00);

    // R2 status sweep over all ready patterns
    for (int r = 0; r < 16; r++) begin
      drv_ready = 4'(r);
      io_read(BASE, d);
      check("R2 status", 16'(d), 16'(exp_status(4'(r), 1'b0)));
    end

    // R4 low byte
    io_write(BASE + 1, 8'hA5);
    check("R4 no start", 16'(eng_start), 16'd0);
    check("R4 pb low", eng_pb_addr, 16'h00A5);

    // R5 high byte and start pulse
    io_write(BASE + 2, 8'h3C);
    check("R5 start high", 16'(eng_start), 16'd1);
    check("R5 pb full", eng_pb_addr, 16'h3CA5);
    @(negedge clk);
    check("R5 start one cycle", 16'(eng_start), 16'd0);

    // R6 busy ignores start
    eng_busy = 1'b1;
    io_write(BASE + 2, 8'h11);
    check("R6 busy no start", 16'(eng_start), 16'd0);
    check("R6 busy addr kept", eng_pb_addr, 16'h3CA5);
    eng_busy = 1'b0;

    // R6 back-to-back high writes: only the first starts
    @(negedge clk);
    io_addr = BASE + 2; io_wdata = 8'h22; io_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R6 first start", 16'(eng_start), 16'd1);
    io_wdata = 8'h33;
    @(posedge clk);
    @(negedge clk);
    io_wr = 1'b0;
    check("R6 second ignored", 16'(eng_start), 16'd0);
    check("R6 second addr kept", eng_pb_addr, 16'h22A5);

    // R7 / R3 error completions, every error byte
    for (int e = 0; e < 256; e++) begin
      done_pulse(1'b0, 1'b1, 8'(e));
      io_read(BASE + 1, d); check("R3 type error", 16'(d), 16'h00);
      io_read(BASE + 3, d); check("R7 error byte", 16'(d), 16'(e));
    end

    // R7 / R3 ready completion, permuted drive bits taken live
    done_pulse(1'b0, 1'b0, 8'hFF);
    io_read(BASE + 1, d); check("R3 type ready", 16'(d), 16'h02);
    for (int r = 0; r < 16; r++) begin
      drv_ready = 4'(r);
      io_read(BASE + 3, d);
      check("R7 ready byte", 16'(d), 16'(exp_ready(4'(r))));
    end

    // R8 interrupt set only when enabled
    done_pulse(1'b0, 1'b0, 8'h00);
    check("R8 no irq when disabled", 16'(irq), 16'd0);
    done_pulse(1'b1, 1'b1, 8'h42);
    check("R8 irq set", 16'(irq), 16'd1);
    drv_ready = 4'b1001;
    io_read(BASE, d); check("R8 status flag", 16'(d), 16'(exp_status(4'b1001, 1'b1)));

    // R11 reads elsewhere keep the flag
    io_read(BASE + 1, d);
    check("R11 type read keeps irq", 16'(irq), 16'd1);

    // R9 result read clears
    io_read(BASE + 3, d);
    check("R9 result while flagged", 16'(d), 16'h42);
    check("R9 irq cleared", 16'(irq), 16'd0);
    m_irq = 1'b0;

    // R9 completion in the same cycle as the clearing read
    done_pulse(1'b1, 1'b1, 8'h81);
    @(negedge clk);
    io_addr = BASE + 3; io_rd = 1'b1;
    eng_done = 1'b1; eng_irq_en = 1'b1; eng_err = 1'b1; eng_err_bits = 8'h18;
    @(posedge clk);
    @(negedge clk);
    io_rd = 1'b0; eng_done = 1'b0; eng_irq_en = 1'b0; eng_err = 1'b0;
    m_err = 8'h18;
    check("R9 done wins", 16'(irq), 16'd1);
    io_read(BASE + 3, d);
    check("R9 new result", 16'(d), 16'h18);
    check("R9 cleared after", 16'(irq), 16'd0);

    // R11 writes at read-only and unused offsets change nothing
    done_pulse(1'b1, 1'b1, 8'h5A);
    pb = eng_pb_addr;
    foreach (d[i]) ;
    for (int o = 0; o < 7; o++) begin
      if (o == 1 || o == 2) continue;
      io_write(8'(BASE + o), 8'hFF);
      check("R11 ro write start", 16'(eng_start), 16'd0);
      check("R11 ro write sub_reset", 16'(sub_reset), 16'd0);
      check("R11 ro write addr", eng_pb_addr, pb);
      check("R11 ro write irq", 16'(irq), 16'd1);
    end
    io_read(BASE + 1, d); check("R11 type kept", 16'(d), 16'h00);
    io_read(BASE + 3, d); check("R11 result kept", 16'(d), 16'h5A);
    m_irq = 1'b0;

    // R11 full port sweep with the flag clear
    drv_ready = 4'b0110;
    for (int a = 0; a < 256; a++) begin
      io_read(8'(a), d);
      check("R11 read sweep", 16'(d), 16'(exp_read(8'(a), 4'b0110, m_irq, m_type, m_err)));
    end

    // R10 reset port
    done_pulse(1'b1, 1'b0, 8'h00);
    io_write(BASE + 1, 8'h77);
    @(negedge clk);
    io_addr = BASE + 7; io_wdata = 8'h00; io_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    io_wr = 1'b0;
    check("R10 sub_reset pulse", 16'(sub_reset), 16'd1);
    check("R10 irq cleared", 16'(irq), 16'd0);
    check("R10 addr cleared", eng_pb_addr, 16'h0000);
    @(negedge clk);
    check("R10 sub_reset one cycle", 16'(sub_reset), 16'd0);
    io_read(BASE + 1, d); check("R10 type cleared", 16'(d), 16'h00);
    io_read(BASE + 3, d); check("R10 result cleared", 16'(d), 16'h00);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule